// File: doc/BRIEF.md
# Direct-Mapped Read Cache with Per-Entry Valid Bits

This block is a 256-byte direct-mapped read cache placed between a processor access port and an external bus. It has 16 lines, and each line holds four 32-bit entries under a single tag. Every entry carries its own valid bit. One entry can therefore be fetched alone with a single bus transfer, or the whole line can be refilled with a four-beat burst. In a burst, the requested longword is handed back to the processor as soon as it arrives.

A lookup that hits answers one cycle after the request is accepted and uses no bus cycle. Every other access becomes an external transfer, and the caller holds off until that transfer finishes. Whether a lookup or a fill happens depends on several controls:

- a software enable bit;
- a global disable input that overrides the enable bit;
- an inhibit flag the bus returns with each data beat;
- a cache-inhibit attribute carried by each access;
- a flag marking the access's address translation as invalid.

Writes are always sent to the bus. A write drops any matching cached entry.

Top module: `dmc_cache`

## Requirements
- R1: After reset, and in the cycle after `flush` is high, every entry is invalid, so the next read lookup misses. `req_ready` is 1, and `rsp_valid` and `bus_req` are 0 after reset.
- R2: The address split is byte offset [1:0], entry [3:2], line [7:4] and tag [31:8]. A read hits when the cache is active, `req_xlat_bad` is 0, the stored tag of the line equals address [31:8] and the addressed entry is valid. A hit gives `rsp_valid`=1 and `rsp_hit`=1 with the stored word in the cycle after acceptance, and no bus cycle.
- R3: A single-entry fill sets only the addressed entry valid. A fill whose tag differs from the line's stored tag first clears all four entry valid bits of that line.
- R4: A fillable read miss with `cfg_burst`=1 runs a burst with `bus_burst`=1: four beats at line base + 4*((e+i) mod 4) for i=0..3, where e is the requested entry. Every beat is stored. With `cfg_burst`=0 there is one beat at the longword address.
- R5: On a read miss, `rsp_valid`=1 with `rsp_hit`=0 and the first beat's data in the cycle after that beat's `bus_ack`, before the rest of a burst.
- R6: The cache is active only when `cfg_enable`=1 and `cache_off`=0. When it is inactive, reads never hit, nothing is filled, no burst is run, and stored contents are kept for later.
- R7: A beat acknowledged with `bus_inhibit`=1 is not stored. Other beats of the same burst are unaffected.
- R8: `bus_nocache` equals the access's `req_ci` for the whole external cycle, for reads and writes. A read with `req_ci`=1 that misses is a single beat and fills nothing. A read with `req_ci`=1 that hits is served from the cache, because the attribute is ignored on a hit.
- R9: A read with `req_xlat_bad`=1 always goes to the bus, even if its entry is cached. Fill rules stay as in R4 and R8.
- R10: A write is one beat with `bus_write`=1 and `bus_wdata` = `req_wdata`. Its completion is `rsp_valid`=1, `rsp_hit`=0, `rsp_data`=0. If the line tag matches, the addressed entry becomes invalid.
- R11: While `bus_req` is 1, `req_ready` is 0 and `bus_addr` stays constant until `bus_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_enable | input | 1 | Cache enable control bit |
| cfg_burst | input | 1 | Use four-beat line fills on fillable misses |
| cache_off | input | 1 | Global disable, overrides cfg_enable |
| flush | input | 1 | Invalidate all entries |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Block can accept a request |
| req_addr | input | 32 | Access byte address |
| req_write | input | 1 | Access is a write |
| req_wdata | input | 32 | Write data |
| req_ci | input | 1 | Cache-inhibit attribute of the access |
| req_xlat_bad | input | 1 | Translation invalid, force external path |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Response came from the cache |
| rsp_data | output | 32 | Read data (0 for writes) |
| bus_req | output | 1 | External transfer request |
| bus_addr | output | 32 | Longword address of current beat |
| bus_write | output | 1 | External transfer is a write |
| bus_wdata | output | 32 | External write data |
| bus_burst | output | 1 | Transfer is a four-beat line fill |
| bus_nocache | output | 1 | Cache-inhibit out for external cycle |
| bus_ack | input | 1 | Beat acknowledge |
| bus_rdata | input | 32 | Beat read data |
| bus_inhibit | input | 1 | Do not cache this beat |

## Verification
The bench attacks several corner cases:

- **Burst starting mid-line.** A burst that starts at entry 2 or 3 must wrap around. A design with a linear fill order puts wrong addresses on the bus and returns late or wrong critical data.
- **Two tags on one line.** Alternating tags on the same line checks that a stale entry from the old tag cannot hit. Keeping old valid bits would produce false hits with foreign data.
- **Inhibit on one beat.** An inhibit on a single middle beat, followed by reads of every entry, exposes a design that drops or keeps the wrong beat.
- **Controls on cached entries.** The disable input, the cache-inhibit attribute, the invalid-translation flag and writes are each applied to entries already cached. A design that mixes up these controls either hits when it must go to the bus, or misses when a cached entry with the inhibit attribute must still hit.

// File: rtl/dmc_pkg.sv
// Shared types for the direct-mapped read cache.
// Assumes: nothing beyond SystemVerilog 2017.
package dmc_pkg;
    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_BUS  = 1'b1
    } dmc_state_e;
endpackage

// File: rtl/dmc_store.sv
// Tag, per-entry valid and data arrays of the cache.
// Lookup is combinational; fill, write-invalidate and flush update at the clock edge.
// Assumes: fill and invalidate never occur in the same cycle; flush has priority.
module dmc_store #(
    parameter int LINES   = 16,
    parameter int ENTRIES = 4,
    parameter int TAG_W   = 24,
    parameter int DATA_W  = 32,
    localparam int LINE_W = $clog2(LINES),
    localparam int ENT_W  = $clog2(ENTRIES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic [LINE_W-1:0] lk_line,
    input  logic [ENT_W-1:0]  lk_entry,
    input  logic [TAG_W-1:0]  lk_tag,
    output logic              lk_hit,
    output logic [DATA_W-1:0] lk_data,
    input  logic              wr_en,
    input  logic [LINE_W-1:0] wr_line,
    input  logic [ENT_W-1:0]  wr_entry,
    input  logic [TAG_W-1:0]  wr_tag,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              inv_en,
    input  logic [LINE_W-1:0] inv_line,
    input  logic [ENT_W-1:0]  inv_entry,
    input  logic [TAG_W-1:0]  inv_tag
);
    logic [TAG_W-1:0]   tag_q   [LINES];
    logic [ENTRIES-1:0] valid_q [LINES];
    logic [DATA_W-1:0]  data_q  [LINES][ENTRIES];

    // Combinational lookup of the addressed line and entry.
    always_comb begin
        lk_hit  = valid_q[lk_line][lk_entry] && (tag_q[lk_line] == lk_tag);
        lk_data = data_q[lk_line][lk_entry];
    end

    // Tag and valid bits: reset, flush, fill with tag replacement, write invalidate.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            for (int i = 0; i < LINES; i++) begin
                valid_q[i] <= '0;
                if (!rst_n) tag_q[i] <= '0;
            end
        end else if (wr_en) begin
            if (tag_q[wr_line] != wr_tag) begin
                tag_q[wr_line]   <= wr_tag;
                valid_q[wr_line] <= ENTRIES'(1) << wr_entry;
            end else begin
                valid_q[wr_line][wr_entry] <= 1'b1;
            end
        end else if (inv_en && (tag_q[inv_line] == inv_tag)) begin
            valid_q[inv_line][inv_entry] <= 1'b0;
        end
    end

    // Data array write on fill; contents need no reset.
    always_ff @(posedge clk) begin
        if (wr_en) data_q[wr_line][wr_entry] <= wr_data;
    end

    p_flush_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !lk_hit);
    p_fill_sets_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !flush && lk_line == wr_line && lk_entry == wr_entry && lk_tag == wr_tag)
        |=> $stable(lk_line) && $stable(lk_entry) && $stable(lk_tag) |-> lk_hit);
endmodule

// File: rtl/dmc_ctrl.sv
// Access sequencer: decides hit or external transfer, runs single or
// wrap-around burst beats, returns the requested word, drives fill writes.
// Assumes: bus holds nothing between beats; cfg inputs are sampled at acceptance.
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int ENTRIES = 4,
    localparam int OFF_W  = $clog2(DATA_W/8),
    localparam int ENT_W  = $clog2(ENTRIES),
    localparam int LADR_W = ADDR_W - OFF_W - ENT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cache_on,
    input  logic              cfg_burst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [LADR_W-1:0] req_laddr,
    input  logic [ENT_W-1:0]  req_entry,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_ci,
    input  logic              req_xlat_bad,
    input  logic              lk_hit,
    input  logic [DATA_W-1:0] lk_data,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_burst,
    output logic              bus_nocache,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_inhibit,
    output logic              fill_en,
    output logic [LADR_W-1:0] fill_laddr,
    output logic [ENT_W-1:0]  fill_entry,
    output logic              inv_en
);
    dmc_state_e        state_q;
    logic [LADR_W-1:0] laddr_q;
    logic [ENT_W-1:0]  beat_q;
    logic [ENT_W-1:0]  left_q;
    logic              write_q, ci_q, fill_q, burst_q, first_q;
    logic [DATA_W-1:0] wdata_q;
    logic              accept, take_hit;

    // Acceptance and hit decision for a new access.
    always_comb begin
        accept   = req_valid && (state_q == ST_IDLE);
        take_hit = cache_on && !req_write && !req_xlat_bad && lk_hit;
    end

    // Port-facing outputs derived from the sequencer state.
    always_comb begin
        req_ready   = (state_q == ST_IDLE);
        bus_req     = (state_q == ST_BUS);
        bus_addr    = {laddr_q, beat_q, {OFF_W{1'b0}}};
        bus_write   = write_q;
        bus_wdata   = wdata_q;
        bus_burst   = burst_q;
        bus_nocache = ci_q;
        fill_en     = bus_req && bus_ack && fill_q && !bus_inhibit;
        fill_laddr  = laddr_q;
        fill_entry  = beat_q;
        inv_en      = accept && req_write;
    end

    // Sequencer: idle lookup, then one or four beats on the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            rsp_valid <= 1'b0;
            rsp_hit   <= 1'b0;
            rsp_data  <= '0;
            laddr_q   <= '0;
            beat_q    <= '0;
            left_q    <= '0;
            write_q   <= 1'b0;
            ci_q      <= 1'b0;
            fill_q    <= 1'b0;
            burst_q   <= 1'b0;
            first_q   <= 1'b0;
            wdata_q   <= '0;
        end else begin
            rsp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept && take_hit) begin
                        rsp_valid <= 1'b1;
                        rsp_hit   <= 1'b1;
                        rsp_data  <= lk_data;
                    end else if (accept) begin
                        state_q <= ST_BUS;
                        laddr_q <= req_laddr;
                        beat_q  <= req_entry;
                        write_q <= req_write;
                        wdata_q <= req_wdata;
                        ci_q    <= req_ci;
                        fill_q  <= cache_on && !req_write && !req_ci;
                        burst_q <= cache_on && !req_write && !req_ci && cfg_burst;
                        left_q  <= (cache_on && !req_write && !req_ci && cfg_burst)
                                   ? ENT_W'(ENTRIES - 1) : '0;
                        first_q <= 1'b1;
                    end
                end
                ST_BUS: begin
                    if (bus_ack) begin
                        if (first_q) begin
                            rsp_valid <= 1'b1;
                            rsp_hit   <= 1'b0;
                            rsp_data  <= write_q ? '0 : bus_rdata;
                            first_q   <= 1'b0;
                        end
                        beat_q <= beat_q + 1'b1;
                        if (left_q == '0) begin
                            state_q <= ST_IDLE;
                            burst_q <= 1'b0;
                        end else begin
                            left_q <= left_q - 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    p_addr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr)));
    p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> !req_ready);
    p_burst_cacheable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_burst) |-> (!bus_nocache && !bus_write));
    p_no_hit_off_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !cache_on) |=> !(rsp_valid && rsp_hit));
    p_xlat_external_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_xlat_bad) |=> bus_req);
    p_write_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_write) |-> !bus_burst);
    p_crit_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && bus_ack && first_q) |=> (rsp_valid && !rsp_hit));
endmodule

// File: rtl/dmc_cache.sv
// Top of the direct-mapped read cache: splits the address, combines the
// enable controls and wires the sequencer to the storage arrays.
// Assumes: req_addr byte offset bits are not needed (longword accesses).
module dmc_cache #(
    parameter int ADDR_W  = 32,
    parameter int DATA_W  = 32,
    parameter int LINES   = 16,
    parameter int ENTRIES = 4,
    localparam int OFF_W  = $clog2(DATA_W/8),
    localparam int ENT_W  = $clog2(ENTRIES),
    localparam int LINE_W = $clog2(LINES),
    localparam int TAG_W  = ADDR_W - LINE_W - ENT_W - OFF_W,
    localparam int LADR_W = ADDR_W - OFF_W - ENT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_enable,
    input  logic              cfg_burst,
    input  logic              cache_off,
    input  logic              flush,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              req_ci,
    input  logic              req_xlat_bad,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [DATA_W-1:0] rsp_data,
    output logic              bus_req,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_write,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_burst,
    output logic              bus_nocache,
    input  logic              bus_ack,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_inhibit
);
    logic              cache_on;
    logic              lk_hit;
    logic [DATA_W-1:0] lk_data;
    logic              fill_en, inv_en;
    logic [LADR_W-1:0] fill_laddr;
    logic [ENT_W-1:0]  fill_entry;
    logic              unused_offset;

    // Cache is active only when enabled and not globally disabled.
    assign cache_on      = cfg_enable && !cache_off;
    assign unused_offset = ^req_addr[OFF_W-1:0];

    dmc_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .ENTRIES(ENTRIES)
    ) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cache_on    (cache_on),
        .cfg_burst   (cfg_burst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_laddr   (req_addr[ADDR_W-1:OFF_W+ENT_W]),
        .req_entry   (req_addr[OFF_W +: ENT_W]),
        .req_write   (req_write),
        .req_wdata   (req_wdata),
        .req_ci      (req_ci),
        .req_xlat_bad(req_xlat_bad),
        .lk_hit      (lk_hit),
        .lk_data     (lk_data),
        .rsp_valid   (rsp_valid),
        .rsp_hit     (rsp_hit),
        .rsp_data    (rsp_data),
        .bus_req     (bus_req),
        .bus_addr    (bus_addr),
        .bus_write   (bus_write),
        .bus_wdata   (bus_wdata),
        .bus_burst   (bus_burst),
        .bus_nocache (bus_nocache),
        .bus_ack     (bus_ack),
        .bus_rdata   (bus_rdata),
        .bus_inhibit (bus_inhibit),
        .fill_en     (fill_en),
        .fill_laddr  (fill_laddr),
        .fill_entry  (fill_entry),
        .inv_en      (inv_en)
    );

    dmc_store #(
        .LINES  (LINES),
        .ENTRIES(ENTRIES),
        .TAG_W  (TAG_W),
        .DATA_W (DATA_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (flush),
        .lk_line  (req_addr[OFF_W+ENT_W +: LINE_W]),
        .lk_entry (req_addr[OFF_W +: ENT_W]),
        .lk_tag   (req_addr[ADDR_W-1 -: TAG_W]),
        .lk_hit   (lk_hit),
        .lk_data  (lk_data),
        .wr_en    (fill_en),
        .wr_line  (fill_laddr[LINE_W-1:0]),
        .wr_entry (fill_entry),
        .wr_tag   (fill_laddr[LADR_W-1 -: TAG_W]),
        .wr_data  (bus_rdata),
        .inv_en   (inv_en),
        .inv_line (req_addr[OFF_W+ENT_W +: LINE_W]),
        .inv_entry(req_addr[OFF_W +: ENT_W]),
        .inv_tag  (req_addr[ADDR_W-1 -: TAG_W])
    );
endmodule

// File: tb/sim_dmc_cache.sv
`timescale 1ns/1ps
module sim_dmc_cache;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_enable = 1'b1, cfg_burst = 1'b0, cache_off = 1'b0, flush = 1'b0;
    logic        req_valid = 1'b0, req_write = 1'b0, req_ci = 1'b0, req_xlat_bad = 1'b0;
    logic [31:0] req_addr = '0, req_wdata = '0;
    logic        req_ready, rsp_valid, rsp_hit;
    logic [31:0] rsp_data;
    logic        bus_req, bus_write, bus_burst, bus_nocache;
    logic [31:0] bus_addr, bus_wdata;
    logic        bus_ack = 1'b0, bus_inhibit = 1'b0;
    logic [31:0] bus_rdata = '0;

    dmc_cache u0 (.*);

    always #2.5 clk = ~clk;

    int checks = 0, errors = 0, cyc = 0;
    bit [31:0] salt = 32'h1357_9bdf;
    bit [23:0] m_tag [16];
    bit [3:0]  m_val [16];
    bit [31:0] m_dat [16][4];
    bit        e_fill, e_burst, e_ci, e_wr;
    bit [31:0] e_wdata, e_base;
    bit [1:0]  e_ent;
    bit [3:0]  e_inh;
    int        beat_n = 0, first_ack_cyc = 0;

    function automatic bit [31:0] mem_word(input bit [31:0] a);
        return ({a[31:2], 2'b00} * 32'h9E37_79B1) ^ salt;
    endfunction

    task automatic chk(input bit ok, input string rq, input bit [31:0] act, input bit [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h (cycle %0d)", rq, act, exp, cyc);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++;
            $display("FAIL watchdog actual=%0d expected<150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    // Bus model: random ack delay, per-beat checks, reference model fill.
    always @(negedge clk) begin
        bus_ack = 1'b0;
        bus_inhibit = 1'b0;
        if (rst_n && bus_req && $urandom_range(0, 3) != 0) begin
            bit [31:0] ea;
            bit [1:0]  ent;
            ent = e_ent + 2'(beat_n);
            ea  = e_base + {28'd0, ent, 2'b00};
            chk(beat_n < (e_burst ? 4 : 1), "R4 beat count", beat_n, e_burst ? 4 : 1);
            chk(bus_addr == ea, "R4 beat address", bus_addr, ea);
            chk(bus_burst == e_burst, "R4 burst flag", bus_burst, e_burst);
            chk(bus_nocache == e_ci, "R8 nocache out", bus_nocache, e_ci);
            chk(bus_write == e_wr, "R10 write flag", bus_write, e_wr);
            if (e_wr) chk(bus_wdata == e_wdata, "R10 write data", bus_wdata, e_wdata);
            bus_rdata   = mem_word(bus_addr);
            bus_inhibit = e_inh[beat_n[1:0]];
            if (beat_n == 0) first_ack_cyc = cyc;
            if (e_fill && !bus_inhibit) begin
                if (m_tag[bus_addr[7:4]] != bus_addr[31:8]) begin
                    m_val[bus_addr[7:4]] = 4'b0;
                    m_tag[bus_addr[7:4]] = bus_addr[31:8];
                end
                m_val[bus_addr[7:4]][ent] = 1'b1;
                m_dat[bus_addr[7:4]][ent] = bus_rdata;
            end
            beat_n++;
            bus_ack = 1'b1;
        end
    end

    task automatic do_access(input bit [31:0] a, input bit wr, input bit ci, input bit xb,
                             input bit [3:0] inh, input string rq);
        bit        on, hit;
        int        nbeats, waited;
        bit [31:0] exp_d, wd;
        while (!req_ready) @(negedge clk);
        on  = cfg_enable && !cache_off;
        hit = on && !wr && !xb && m_val[a[7:4]][a[3:2]] && (m_tag[a[7:4]] == a[31:8]);
        wd  = $urandom;
        e_fill  = on && !wr && !ci;
        e_burst = e_fill && cfg_burst;
        e_ci = ci; e_wr = wr; e_wdata = wd; e_inh = inh;
        e_base = {a[31:4], 4'b0}; e_ent = a[3:2];
        beat_n = 0;
        nbeats = hit ? 0 : (e_burst ? 4 : 1);
        exp_d  = hit ? m_dat[a[7:4]][a[3:2]] : (wr ? 32'd0 : mem_word(a));
        if (wr && m_tag[a[7:4]] == a[31:8]) m_val[a[7:4]][a[3:2]] = 1'b0;
        req_addr = a; req_write = wr; req_ci = ci; req_xlat_bad = xb; req_wdata = wd;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        waited = 0;
        while (!rsp_valid && waited < 60) begin
            @(negedge clk);
            waited++;
        end
        chk(rsp_valid, {rq, " response present"}, rsp_valid, 1);
        chk(rsp_hit == hit, {rq, " hit flag"}, rsp_hit, hit);
        chk(rsp_data == exp_d, {rq, " data"}, rsp_data, exp_d);
        if (!hit) chk(cyc == first_ack_cyc + 1, "R5 response timing", cyc, first_ack_cyc + 1);
        while (!req_ready) @(negedge clk);
        chk(beat_n == nbeats, {rq, " beats"}, beat_n, nbeats);
    endtask

    task automatic do_flush();
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        for (int i = 0; i < 16; i++) m_val[i] = 4'b0;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 16; i++) begin m_tag[i] = '0; m_val[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R1 reset ready", req_ready, 1);
        chk(rsp_valid == 1'b0, "R1 reset rsp", rsp_valid, 0);
        chk(bus_req == 1'b0, "R1 reset bus", bus_req, 0);
        do_access(32'h0000_1000, 0, 0, 0, 4'h0, "R1 first miss");
        // R2 R3 single fills
        do_access(32'h0000_1000, 0, 0, 0, 4'h0, "R2 hit");
        do_access(32'h0000_1004, 0, 0, 0, 4'h0, "R3 neighbour miss");
        do_access(32'h0000_2000, 0, 0, 0, 4'h0, "R3 conflict fill");
        do_access(32'h0000_1004, 0, 0, 0, 4'h0, "R3 old tag dropped");
        // R4 R5 wrap bursts
        cfg_burst = 1'b1;
        do_access(32'h0000_3058, 0, 0, 0, 4'h0, "R4 burst from entry 2");
        do_access(32'h0000_3050, 0, 0, 0, 4'h0, "R4 wrapped entry 0");
        do_access(32'h0000_305C, 0, 0, 0, 4'h0, "R4 entry 3");
        // R7 inhibit on beat 1
        do_access(32'h0000_4064, 0, 0, 0, 4'b0010, "R7 inhibited burst");
        for (int k = 0; k < 4; k++) do_access(32'h0000_4060 + 4 * k, 0, 0, 0, 4'h0, "R7 per-entry");
        // R6 disable controls keep contents
        cache_off = 1'b1;
        do_access(32'h0000_3050, 0, 0, 0, 4'h0, "R6 global off");
        cache_off = 1'b0; cfg_enable = 1'b0;
        do_access(32'h0000_3054, 0, 0, 0, 4'h0, "R6 enable low");
        cfg_enable = 1'b1;
        do_access(32'h0000_3054, 0, 0, 0, 4'h0, "R6 contents kept");
        // R8 inhibit attribute
        do_access(32'h0000_5070, 0, 1, 0, 4'h0, "R8 ci miss");
        do_access(32'h0000_5070, 0, 0, 0, 4'h0, "R8 ci not filled");
        do_access(32'h0000_5074, 0, 1, 0, 4'h0, "R8 ci hit ignored");
        // R9 invalid translation
        do_access(32'h0000_5078, 0, 0, 1, 4'h0, "R9 forced external");
        // R10 write invalidate
        do_access(32'h0000_507C, 1, 1, 0, 4'h0, "R10 write");
        do_access(32'h0000_507C, 0, 0, 0, 4'h0, "R10 after write");
        // R1 flush
        do_flush();
        do_access(32'h0000_5070, 0, 0, 0, 4'h0, "R1 after flush");
        // Random mix
        for (int n = 0; n < 400; n++) begin
            bit [31:0] a;
            a = {22'd0, 2'($urandom_range(0, 2)), 4'($urandom), 2'($urandom), 2'b00};
            if (n % 50 == 49) salt = $urandom;
            if ($urandom_range(0, 19) == 0) cfg_burst = ~cfg_burst;
            if ($urandom_range(0, 29) == 0) cache_off = ~cache_off;
            if ($urandom_range(0, 29) == 0) cfg_enable = ~cfg_enable;
            if ($urandom_range(0, 39) == 0) do_flush();
            do_access(a, $urandom_range(0, 6) == 0, $urandom_range(0, 9) == 0,
                      $urandom_range(0, 19) == 0,
                      {($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0),
                       ($urandom_range(0, 9) == 0), ($urandom_range(0, 9) == 0)},
                      "R2 random");
        end
        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule